// File: doc/BRIEF.md
# System Control Block Command Decoder

This block holds the control/status word pair through which a host drives the command unit (CU) and receive unit (RU) of a network controller. When the channel-attention input pulses, the block takes in a 16-bit command word. It decodes the CU and RU opcode fields and any software-reset request, and it clears the sticky event bits that the word acknowledges. After that it signals that the word has been consumed. The command and receive engines report their own events on separate inputs, and those events set the same sticky bits.

The block always presents a composed 16-bit status word that packs the event bits together with both unit states. It also pulses a fetch strobe that tells the CU engine to load the command list from its base pointer. The strobe fires only when the CU is not suspended and no list is still pending. The engines themselves, which walk the command list and move frames, sit outside this block.

Top module: `scb_ctrl`

## Requirements
- R1: After hardware reset the status word is 0x0010, and fetch, error and consumed outputs are low. The status word is laid out as: events in bits 15:12 (15 command-complete, 14 frame-received, 13 CU-left-active, 12 RU-left-active), a zero bit 11, the CU state in 10:8, a zero bit 7, the RU state in 6:4, and zeros in 3:0.
- R2: An acknowledge bit 15..12 in a consumed command word clears the event bit at the same position. An engine event that arrives in the same cycle wins and leaves the bit set.
- R3: The CU opcode is taken from command bits 10:8. Opcode 0 leaves the CU unchanged, 1 makes it active (2), and 4 makes it suspended (1) and sets CU-left-active. The CU state is always one of idle 0, suspended 1 or active 2.
- R4: The RU opcode is taken from command bits 6:4. Opcode 0 leaves the RU unchanged, 1 and 2 make it idle (0), and 3 and 4 make it suspended (1) and set RU-left-active.
- R5: The engine inputs set command-complete and frame-received. A receive-stop input sets RU-left-active and forces the RU to suspended, and it overrides any RU opcode in the same cycle.
- R6: Command bit 7 is a software reset. It sets the CU to idle and the RU to suspended, and it clears the events, the error flag and the pending list. The opcode fields of that same word are ignored. Engine events in the same cycle still land.
- R7: One cycle after a channel attention, the fetch strobe pulses if the new CU state is not suspended and no list is pending. The pulse marks a list as pending. A list-done input, or a software reset, clears the pending mark.
- R8: Every channel attention produces a one-cycle consumed pulse in the following cycle.
- R9: A CU opcode outside {0,1,4} or an RU opcode outside {0..4} leaves that unit's state unchanged and sets a sticky error output. Only a reset clears the error output.
- R10: All outputs are registered. The effect of a channel attention or an event input appears in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ca_i | input | 1 | Channel attention: take in cmd_i this cycle |
| cmd_i | input | 16 | Command word |
| evt_cmd_done_i | input | 1 | CU engine: command completed with interrupt |
| evt_frame_i | input | 1 | RU engine: frame received |
| evt_rx_stop_i | input | 1 | RU engine: receive unit stopped |
| list_done_i | input | 1 | CU engine: command list finished |
| status_o | output | 16 | Composed status word |
| fetch_o | output | 1 | Fetch command list strobe |
| cmd_clr_o | output | 1 | Command word consumed pulse |
| err_o | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench builds the block with its default 3-bit opcode fields and 4-bit state nibbles. These widths cover the real command layout, so every opcode value, including the five unknown CU codes and three unknown RU codes, can be reached. Random command words, with reset requests kept rare, drive the block into long runs of acknowledges that collide with engine events and with fetch strobes whose pending mark is still set. A directed walk covers the start, abort, acknowledge, reset-priority and unknown-opcode cases, and it checks literal status values at each step.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int OPC_W  = 3;
  localparam int NIB_W  = 4;
  localparam int N_EVT  = 4;

  localparam int EV_CX  = 3;
  localparam int EV_FR  = 2;
  localparam int EV_CNA = 1;
  localparam int EV_RNR = 0;

  typedef enum logic [OPC_W-1:0] {
    CU_IDLE = 3'd0,
    CU_SUSP = 3'd1,
    CU_ACT  = 3'd2
  } cu_state_e;

  typedef enum logic [OPC_W-1:0] {
    RU_IDLE  = 3'd0,
    RU_SUSP  = 3'd1,
    RU_READY = 3'd4
  } ru_state_e;
endpackage

// File: rtl/scb_cu_unit.sv
module scb_cu_unit
  import scb_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ca_i,
  input  logic          srst_i,
  input  logic [OW-1:0] opc_i,
  output cu_state_e     state_o,
  output cu_state_e     state_nxt_o,
  output logic          left_o,
  output logic          bad_o
);
  cu_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    left_o  = 1'b0;
    bad_o   = 1'b0;
    if (ca_i && srst_i) begin
      state_n = CU_IDLE;
    end else if (ca_i) begin
      case (opc_i)
        OW'(0): state_n = state_q;
        OW'(1): state_n = CU_ACT;
        OW'(4): begin
          state_n = CU_SUSP;
          left_o  = 1'b1;
        end
        default: bad_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CU_IDLE;
    else        state_q <= state_n;
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_n;

  AST_CU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == CU_IDLE || state_q == CU_SUSP || state_q == CU_ACT); // R3
  AST_CU_START: assert property (@(posedge clk) disable iff (!rst_n)
    ca_i && !srst_i && opc_i == OW'(1) |=> state_q == CU_ACT); // R3
endmodule

// File: rtl/scb_ru_unit.sv
module scb_ru_unit
  import scb_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ca_i,
  input  logic          srst_i,
  input  logic          stop_i,
  input  logic [OW-1:0] opc_i,
  output ru_state_e     state_o,
  output logic          left_o,
  output logic          bad_o
);
  ru_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    left_o  = 1'b0;
    bad_o   = 1'b0;
    if (ca_i && srst_i) begin
      state_n = RU_SUSP;
    end else if (ca_i) begin
      case (opc_i)
        OW'(0): state_n = state_q;
        OW'(1), OW'(2): state_n = RU_IDLE;
        OW'(3), OW'(4): begin
          state_n = RU_SUSP;
          left_o  = 1'b1;
        end
        default: bad_o = 1'b1;
      endcase
    end
    if (stop_i) begin
      state_n = RU_SUSP;
      left_o  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RU_SUSP;
    else        state_q <= state_n;
  end

  assign state_o = state_q;

  AST_RU_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> state_q == RU_SUSP); // R5
  AST_RU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == RU_IDLE || state_q == RU_SUSP || state_q == RU_READY); // R4
endmodule

// File: rtl/scb_evt_bank.sv
module scb_evt_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] ev_o
);
  logic [N-1:0] ev_q, ev_n;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (set_i[i])      ev_n[i] = 1'b1;
      else if (clr_i)    ev_n[i] = 1'b0;
      else if (ack_i[i]) ev_n[i] = 1'b0;
      else               ev_n[i] = ev_q[i];
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i[i] && !set_i[i] |=> !ev_q[i]); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> ev_q[i]); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_n;
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int CMD_W   = 16,
  parameter int CU_LSB  = 8,
  parameter int RU_LSB  = 4,
  parameter int RST_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ca_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             evt_cmd_done_i,
  input  logic             evt_frame_i,
  input  logic             evt_rx_stop_i,
  input  logic             list_done_i,
  output logic [CMD_W-1:0] status_o,
  output logic             fetch_o,
  output logic             cmd_clr_o,
  output logic             err_o
);
  localparam int ACK_LSB = CMD_W - N_EVT;

  logic             srst;
  logic [N_EVT-1:0] ack, evt_set, ev;
  cu_state_e        cu_q, cu_n;
  ru_state_e        ru_q;
  logic             cu_left, cu_bad, ru_left, ru_bad;
  logic             pend_q, pend_n, pend_base;
  logic             err_q, err_n;
  logic             fetch_q, fetch_n;
  logic             clr_q;
  logic             unused_bits;

  assign srst        = ca_i & cmd_i[RST_BIT];
  assign ack         = ca_i ? cmd_i[CMD_W-1:ACK_LSB] : '0;
  assign unused_bits = ^{cmd_i[RU_LSB-1:0], cmd_i[CU_LSB+OPC_W], cmd_i[RU_LSB+OPC_W]};

  scb_cu_unit #(.OW(OPC_W)) i_cu (
    .clk(clk), .rst_n(rst_n), .ca_i(ca_i), .srst_i(srst),
    .opc_i(cmd_i[CU_LSB+:OPC_W]), .state_o(cu_q), .state_nxt_o(cu_n),
    .left_o(cu_left), .bad_o(cu_bad)
  );

  scb_ru_unit #(.OW(OPC_W)) i_ru (
    .clk(clk), .rst_n(rst_n), .ca_i(ca_i), .srst_i(srst),
    .stop_i(evt_rx_stop_i), .opc_i(cmd_i[RU_LSB+:OPC_W]),
    .state_o(ru_q), .left_o(ru_left), .bad_o(ru_bad)
  );

  always_comb begin
    evt_set         = '0;
    evt_set[EV_CX]  = evt_cmd_done_i;
    evt_set[EV_FR]  = evt_frame_i;
    evt_set[EV_CNA] = cu_left;
    evt_set[EV_RNR] = ru_left;
  end

  scb_evt_bank #(.N(N_EVT)) i_evt (
    .clk(clk), .rst_n(rst_n), .clr_i(srst),
    .set_i(evt_set), .ack_i(ack), .ev_o(ev)
  );

  always_comb begin
    pend_base = (srst || list_done_i) ? 1'b0 : pend_q;
    fetch_n   = ca_i && (cu_n != CU_SUSP) && !pend_base;
    pend_n    = pend_base | fetch_n;
    err_n     = srst ? 1'b0 : (err_q | cu_bad | ru_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      fetch_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      err_q   <= err_n;
      fetch_q <= fetch_n;
      clr_q   <= ca_i;
    end
  end

  assign status_o  = {ev, 1'b0, cu_q, 1'b0, ru_q, {RU_LSB{1'b0}}};
  assign fetch_o   = fetch_q;
  assign cmd_clr_o = clr_q;
  assign err_o     = err_q;

  AST_CLR_AFTER_CA: assert property (@(posedge clk) disable iff (!rst_n)
    ca_i |=> cmd_clr_o); // R8
  AST_FETCH_NOT_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> status_o[CU_LSB+:OPC_W] != 3'd1); // R7
  AST_FETCH_NEEDS_CA: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> cmd_clr_o); // R7
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ca_i && cmd_i[RST_BIT] && !evt_cmd_done_i && !evt_frame_i && !evt_rx_stop_i
    |=> status_o == 16'h0010 && !err_o); // R6
  AST_ABORT_CNA: assert property (@(posedge clk) disable iff (!rst_n)
    ca_i && !cmd_i[RST_BIT] && cmd_i[CU_LSB+:OPC_W] == 3'd4 |=> status_o[13]); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3:0] == 4'h0); // R1
endmodule

// File: tb/test_scb_ctrl.sv
module test_scb_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, ca_i, evt_cmd_done_i, evt_frame_i, evt_rx_stop_i, list_done_i;
  logic [15:0] cmd_i, status_o;
  logic        fetch_o, cmd_clr_o, err_o;

  int n_chk, n_err;
  logic [2:0] m_cu, m_ru;
  logic [3:0] m_ev;
  logic       m_err, m_pend, m_fetch, m_clr;

  scb_ctrl i_scb_ctrl (
    .clk(clk), .rst_n(rst_n), .ca_i(ca_i), .cmd_i(cmd_i),
    .evt_cmd_done_i(evt_cmd_done_i), .evt_frame_i(evt_frame_i),
    .evt_rx_stop_i(evt_rx_stop_i), .list_done_i(list_done_i),
    .status_o(status_o), .fetch_o(fetch_o), .cmd_clr_o(cmd_clr_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_status();
    return {m_ev, 1'b0, m_cu, 1'b0, m_ru, 4'h0};
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(logic ca, logic [15:0] cmd, logic cx, logic fr, logic rs, logic ld);
    logic srst, bad, cna, rnr, pb;
    logic [2:0] cu_n, ru_n;
    logic [3:0] set;
    srst = ca & cmd[7];
    bad = 0; cna = 0; rnr = 0;
    cu_n = m_cu; ru_n = m_ru;
    if (srst) begin
      cu_n = 3'd0; ru_n = 3'd1;
    end else if (ca) begin
      case (cmd[10:8])
        3'd0: ;
        3'd1: cu_n = 3'd2;
        3'd4: begin cu_n = 3'd1; cna = 1; end
        default: bad = 1;
      endcase
      case (cmd[6:4])
        3'd0: ;
        3'd1, 3'd2: ru_n = 3'd0;
        3'd3, 3'd4: begin ru_n = 3'd1; rnr = 1; end
        default: bad = 1;
      endcase
    end
    if (rs) begin ru_n = 3'd1; rnr = 1; end
    set = {cx, fr, cna, rnr};
    m_ev = srst ? set : ((m_ev & ~(ca ? cmd[15:12] : 4'h0)) | set);
    m_err = srst ? 1'b0 : (m_err | bad);
    pb = (srst | ld) ? 1'b0 : m_pend;
    m_fetch = ca && (cu_n != 3'd1) && !pb;
    m_pend = pb | m_fetch;
    m_clr = ca;
    m_cu = cu_n; m_ru = ru_n;
  endtask

  task automatic cycle(string tag, logic ca, logic [15:0] cmd, logic cx, logic fr, logic rs, logic ld);
    ca_i = ca; cmd_i = cmd; evt_cmd_done_i = cx; evt_frame_i = fr;
    evt_rx_stop_i = rs; list_done_i = ld;
    model_step(ca, cmd, cx, fr, rs, ld);
    @(negedge clk);
    chk(tag, "status", status_o, exp_status());
    chk("R7", "fetch", {15'h0, fetch_o}, {15'h0, m_fetch});
    chk("R9", "err", {15'h0, err_o}, {15'h0, m_err});
    chk("R8", "consumed", {15'h0, cmd_clr_o}, {15'h0, m_clr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    n_chk = 0; n_err = 0;
    rst_n = 0; ca_i = 0; cmd_i = 0; evt_cmd_done_i = 0; evt_frame_i = 0;
    evt_rx_stop_i = 0; list_done_i = 0;
    m_cu = 0; m_ru = 1; m_ev = 0; m_err = 0; m_pend = 0; m_fetch = 0; m_clr = 0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset status", status_o, 16'h0010);
    chk("R1", "reset outs", {13'h0, fetch_o, err_o, cmd_clr_o}, 16'h0);
    rst_n = 1;
    @(negedge clk);

    cycle("R7", 1, 16'h0000, 0, 0, 0, 0);
    chk("R7", "first fetch", {15'h0, fetch_o}, 16'h1);
    chk("R8", "consumed pulse", {15'h0, cmd_clr_o}, 16'h1);
    cycle("R3", 1, 16'h0100, 0, 0, 0, 0);
    chk("R3", "cu start", status_o, 16'h0210);
    chk("R7", "pending blocks fetch", {15'h0, fetch_o}, 16'h0);
    cycle("R10", 0, 16'h0000, 0, 0, 0, 1);
    chk("R8", "no consumed without ca", {15'h0, cmd_clr_o}, 16'h0);
    cycle("R4", 1, 16'h0010, 0, 0, 0, 0);
    chk("R4", "ru start", status_o, 16'h0200);
    chk("R7", "fetch after list done", {15'h0, fetch_o}, 16'h1);
    cycle("R3", 1, 16'h0400, 0, 0, 0, 1);
    chk("R3", "cu abort", status_o, 16'h2100);
    chk("R7", "no fetch when suspended", {15'h0, fetch_o}, 16'h0);
    cycle("R5", 0, 16'h0000, 1, 1, 0, 0);
    chk("R5", "engine events", status_o, 16'hE100);
    cycle("R2", 1, 16'h4000, 0, 0, 0, 0);
    chk("R2", "ack frame", status_o, 16'hA100);
    cycle("R2", 1, 16'h8000, 1, 0, 0, 0);
    chk("R2", "event beats ack", status_o, 16'hA100);
    cycle("R4", 1, 16'h0040, 0, 0, 0, 0);
    chk("R4", "ru abort", status_o, 16'hB110);
    cycle("R9", 1, 16'h0700, 0, 0, 0, 0);
    chk("R9", "bad cu opcode", {status_o[10:8], 12'h0, err_o}, {3'd1, 12'h0, 1'b1});
    cycle("R9", 1, 16'h0250, 0, 0, 0, 0);
    chk("R9", "bad ru opcode", {status_o[6:4], 12'h0, err_o}, {3'd1, 12'h0, 1'b1});
    cycle("R6", 1, 16'hF1C0, 0, 0, 0, 0);
    chk("R6", "soft reset priority", status_o, 16'h0010);
    chk("R6", "soft reset clears err", {15'h0, err_o}, 16'h0);
    cycle("R4", 1, 16'h0020, 0, 0, 0, 0);
    chk("R4", "ru resume", status_o[6:4], 16'h0);
    cycle("R5", 1, 16'h0010, 0, 0, 1, 0);
    chk("R5", "stop overrides start", status_o, 16'h1010);
    cycle("R6", 1, 16'h0080, 0, 1, 0, 0);
    chk("R6", "event lands with reset", status_o, 16'h4010);

    for (int k = 0; k < 4000; k++) begin
      logic [15:0] c;
      c = 16'($urandom);
      if ($urandom_range(7) != 0) c[7] = 1'b0;
      cycle("R1", $urandom_range(1) == 1, c, $urandom_range(5) == 0,
            $urandom_range(5) == 0, $urandom_range(9) == 0, $urandom_range(3) == 0);
    end

    cycle("R10", 0, 16'h0000, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule